// File: doc/BRIEF.md
# Four-Step Rotating Value Sequencer

The block stores no step values of its own. It reads four step values, A to D, from its inputs and drives them onto eight parallel lanes. Each lane plays the same four values. Four forward lanes start on successive steps and walk upward through the values. Four reverse lanes start on successive steps and walk downward. One set of step values can therefore drive a melody, its retrograde, and any offset of either.

A free-running 7-bit binary counter sets the position in the sequence. An asynchronous step-clock input is synchronized to the system clock and edge-detected, and the counter advances once per rising edge of that input. An asynchronous clear input forces the counter to zero. The two low counter bits select the step. The five upper bits form a staircase code that rises once per complete four-step cycle. Every lane and the staircase also have a registered complement output.

Top module: `rot_step_seq`

## Requirements
- R1: While `rst_n` is low, every lane output reads 0, every lane complement output reads all ones, `stair_o` reads 0 and `stair_n_o` reads all ones.
- R2: Forward lane k (k = 0..3) outputs `val_i[(k + s) mod 4]`, where s is bits [1:0] of the counter. Index 0 is value A and index 3 is value D, so lanes 0..3 play ABCD, BCDA, CDAB and DABC.
- R3: Reverse lane j (j = 0..3) outputs `val_i[(3 - j - s) mod 4]`, so lanes 0..3 play DCBA, CBAD, BADC and ADCB.
- R4: The counter advances by exactly one for each low-to-high transition of `step_clk_i`. Holding `step_clk_i` high or low for any number of cycles adds no further steps.
- R5: A high level on `clr_i` returns the counter to 0, and every lane returns to the first value of its pattern. If a clear and an advance reach the counter in the same cycle, the clear wins.
- R6: Each complement output equals the bitwise inverse of its companion output, that is, full scale minus the value.
- R7: `stair_o` equals counter bits [6:2], and `stair_n_o` is its inverse. The counter wraps from 127 to 0, so the staircase drops from 31 to 0 while the lanes continue their normal rotation.
- R8: Outputs are registered. A change on `val_i` appears at the outputs one system clock later, with no step edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| step_clk_i | input | 1 | Asynchronous step clock; rising edges advance the counter |
| clr_i | input | 1 | Asynchronous clear; a high level returns the counter to 0 |
| val_i | input | 4 x WIDTH | Step values; element 0 is A, element 3 is D |
| fwd_o | output | 4 x WIDTH | Forward lanes |
| fwd_n_o | output | 4 x WIDTH | Complements of the forward lanes |
| rev_o | output | 4 x WIDTH | Reverse lanes |
| rev_n_o | output | 4 x WIDTH | Complements of the reverse lanes |
| stair_o | output | CNT_W-2 | Staircase code from the counter's upper bits |
| stair_n_o | output | CNT_W-2 | Complement of the staircase code |

## Verification
The bench steps the counter through 130 edges, which covers the full 128-count cycle plus the wrap. At every step it checks all eight lanes, their complements and the staircase. The sweep is repeated with a second set of step values and runs again after a clear. Distinct step values show whether a lane takes the right index and the right direction. The 127-to-0 wrap separates the staircase bits from the step bits. A step clock held high for a long time shows whether the edge detector counts levels instead of edges. Driving clear and step together confirms that clear has priority. A change to the step values with no step edge measures the one-cycle output latency.

// File: rtl/rot_step_seq.sv
module rot_step_seq #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_clk_i,
  input  logic                  clr_i,
  input  logic [3:0][WIDTH-1:0] val_i,
  output logic [3:0][WIDTH-1:0] fwd_o,
  output logic [3:0][WIDTH-1:0] fwd_n_o,
  output logic [3:0][WIDTH-1:0] rev_o,
  output logic [3:0][WIDTH-1:0] rev_n_o,
  output logic [CNT_W-3:0]      stair_o,
  output logic [CNT_W-3:0]      stair_n_o
);
  localparam int STAIR_W = CNT_W - 2;

  logic [2:0]       edge_sh;
  logic [1:0]       clr_sh;
  logic             adv, clr_s;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       step;

  logic [3:0][WIDTH-1:0] fwd_d, rev_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_sh <= '0;
      clr_sh  <= '0;
    end else begin
      edge_sh <= {edge_sh[1:0], step_clk_i};
      clr_sh  <= {clr_sh[0], clr_i};
    end

  assign adv   = edge_sh[1] & ~edge_sh[2];
  assign clr_s = clr_sh[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (clr_s) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;

  assign step = cnt[1:0];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    localparam logic [1:0] FWD_BASE = 2'(k);
    localparam logic [1:0] REV_BASE = 2'(3 - k);
    logic [1:0] fi, ri;
    assign fi       = FWD_BASE + step;
    assign ri       = REV_BASE - step;
    assign fwd_d[k] = val_i[fi];
    assign rev_d[k] = val_i[ri];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fwd_o     <= '0;
      rev_o     <= '0;
      fwd_n_o   <= '1;
      rev_n_o   <= '1;
      stair_o   <= '0;
      stair_n_o <= '1;
    end else begin
      fwd_o     <= fwd_d;
      rev_o     <= rev_d;
      fwd_n_o   <= ~fwd_d;
      rev_n_o   <= ~rev_d;
      stair_o   <= cnt[CNT_W-1 -: STAIR_W];
      stair_n_o <= ~cnt[CNT_W-1 -: STAIR_W];
    end
endmodule

// File: rtl/rot_step_seq_chk.sv
module rot_step_seq_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  adv,
  input logic                  clr_s,
  input logic [CNT_W-1:0]      cnt,
  input logic [3:0][WIDTH-1:0] val_i,
  input logic [3:0][WIDTH-1:0] fwd_o,
  input logic [3:0][WIDTH-1:0] fwd_n_o,
  input logic [3:0][WIDTH-1:0] rev_o,
  input logic [3:0][WIDTH-1:0] rev_n_o,
  input logic [CNT_W-3:0]      stair_o,
  input logic [CNT_W-3:0]      stair_n_o
);
  always @(negedge clk)
    if (!rst_n)
      AST_RESET_STATE: assert (fwd_o == '0 && rev_o == '0 && stair_o == '0 && stair_n_o == '1); // R1

  for (genvar k = 0; k < 4; k++) begin : g_chk
    localparam logic [1:0] FB = 2'(k);
    localparam logic [1:0] RB = 2'(3 - k);
    AST_FWD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> fwd_o[k] == $past(val_i[FB + cnt[1:0]])); // R2
    AST_REV_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> rev_o[k] == $past(val_i[RB - cnt[1:0]])); // R3
    AST_LANE_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_n_o[k] == ~fwd_o[k]) && (rev_n_o[k] == ~rev_o[k])); // R6
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(adv) && !$past(clr_s) |-> cnt == $past(cnt) + 1'b1); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(adv) && !$past(clr_s) |-> $stable(cnt)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clr_s) |-> cnt == '0); // R5
  AST_STAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stair_o == $past(cnt[CNT_W-1:2]) && stair_n_o == ~stair_o); // R7
endmodule

bind rot_step_seq rot_step_seq_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .clr_s(clr_s), .cnt(cnt), .val_i(val_i),
  .fwd_o(fwd_o), .fwd_n_o(fwd_n_o), .rev_o(rev_o), .rev_n_o(rev_n_o),
  .stair_o(stair_o), .stair_n_o(stair_n_o)
);

// File: tb/tb_rot_step_seq.sv
module tb_rot_step_seq;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, step_in = 1'b0, clr_in = 1'b0;
  logic [3:0][W-1:0] vals;
  logic [3:0][W-1:0] fwd, fwd_n, rev, rev_n;
  logic [4:0] stair, stair_n;

  int checks = 0, failures = 0, mcnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rot_step_seq #(.WIDTH(W), .CNT_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .step_clk_i(step_in), .clr_i(clr_in), .val_i(vals),
    .fwd_o(fwd), .fwd_n_o(fwd_n), .rev_o(rev), .rev_n_o(rev_n),
    .stair_o(stair), .stair_n_o(stair_n)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (count %0d)", req, act, exp, mcnt);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 4; k++) begin
      int fe, re;
      fe = vals[(k + mcnt) % 4];
      re = vals[(3 - k - (mcnt % 4) + 8) % 4];
      chk("R2 fwd lane", fwd[k], fe);
      chk("R3 rev lane", rev[k], re);
      chk("R6 fwd inverse", fwd_n[k], 255 - fe);
      chk("R6 rev inverse", rev_n[k], 255 - re);
    end
    chk("R7 staircase", stair, (mcnt >> 2) % 32);
    chk("R7 staircase inverse", stair_n, 31 - ((mcnt >> 2) % 32));
  endtask

  task automatic step_once(int hold);
    @(negedge clk) step_in = 1'b1;
    repeat (hold) @(negedge clk);
    step_in = 1'b0;
    repeat (6) @(negedge clk);
    mcnt = (mcnt + 1) % 128;
  endtask

  initial begin
    vals = {8'h44, 8'h33, 8'h22, 8'h11};
    repeat (3) @(negedge clk);
    chk("R1 fwd reset", fwd, 0);
    chk("R1 rev reset", rev, 0);
    chk("R1 fwd_n reset", fwd_n[0], 255);
    chk("R1 stair reset", stair, 0);
    chk("R1 stair_n reset", stair_n, 31);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all();

    for (int i = 0; i < 130; i++) begin
      step_once(6);
      check_all();
    end

    for (int i = 0; i < 4; i++) vals[i] = W'(i * 61 + 7);
    @(negedge clk);
    check_all();
    for (int i = 0; i < 8; i++) begin
      step_once(6);
      check_all();
    end

    // R4: a long high level counts once
    step_once(40);
    check_all();
    repeat (20) @(negedge clk);
    check_all();

    // R5: clear alone
    @(negedge clk) clr_in = 1'b1;
    repeat (4) @(negedge clk);
    clr_in = 1'b0;
    repeat (3) @(negedge clk);
    mcnt = 0;
    check_all();
    chk("R5 fwd lane0 first value", fwd[0], vals[0]);

    for (int i = 0; i < 6; i++) step_once(6);
    check_all();

    // R5: clear and step edge arrive together
    @(negedge clk) begin clr_in = 1'b1; step_in = 1'b1; end
    @(negedge clk);
    @(negedge clk) clr_in = 1'b0;
    repeat (6) @(negedge clk);
    step_in = 1'b0;
    repeat (6) @(negedge clk);
    mcnt = 0;
    check_all();
    chk("R5 clear beats advance", rev[0], vals[3]);

    // R8: value change shows after one clock without a step edge
    step_once(6);
    @(negedge clk) vals = {8'hF0, 8'h0F, 8'hA5, 8'h5A};
    @(negedge clk);
    chk("R8 one-cycle update fwd0", fwd[0], vals[(0 + mcnt) % 4]);
    chk("R8 one-cycle update rev2", rev[2], vals[(3 - 2 - (mcnt % 4) + 8) % 4]);
    check_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule